// File: doc/BRIEF.md
# Display Controller Command Interpreter

This block sits behind the bus slave of a small monochrome display controller and interprets the bytes of each write transaction. A transaction starts in an idle state. There, one control byte picks how the bytes that follow are treated: as commands or as pixel data. Command bytes update the column address, page address, start line and four mode flags. These flags are mirror, all-pixels-on, inverse and display enable. Some commands carry an argument that is only consumed and never used. Pixel bytes go out on a write port into a framebuffer of 132 columns by 8 pages of bytes, and the column advances after each byte.

Bytes arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, so a byte is taken on every clock edge where `in_valid` is high. The source may rely on this, but it must not present a byte while ready is low. A separate end-of-transaction strobe returns the interpreter to idle. A sticky redraw flag tells the refresh logic that the picture changed. That logic clears the flag with `redraw_clr`. An external `invalidate` input also sets it.

Top module: `oled_cmd_parser`

## Requirements
- R1: After reset, column, page, start line and the flags mirror, all_on, inverse and disp_en are 0, redraw is 1, and fb_we, bad_ctrl and bad_cmd are 0. The interpreter starts in idle.
- R2: In idle, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte gives a one-cycle bad_ctrl pulse on the next cycle and changes nothing else. At most one of fb_we, bad_ctrl and bad_cmd is high in any cycle.
- R3: In data mode, a byte taken while column < 132 produces fb_we on the next cycle, with fb_addr = column + page*132 and fb_wdata = the byte, and column then increments. A byte taken while column >= 132 is dropped with no write and no pulse.
- R4: When xfer_end is high on an edge, the interpreter is idle after that edge. A byte taken on the same edge is handled first, in the mode that was current.
- R5: A command byte decoded in command mode returns the interpreter to idle, so each further command needs a new 0x80 prefix.
- R6: Commands 0x00 to 0x0F replace column bits [3:0] with byte bits [3:0]. Commands 0x10 to 0x20 replace column bits [7:4] with byte bits [3:0], so 0x20 clears the high nibble.
- R7: Commands 0xB0 to 0xBF set the page to byte bits [2:0].
- R8: Commands 0xA0/0xA1 clear or set mirror, 0xA4/0xA5 clear or set all_on, 0xA6/0xA7 clear or set inverse, and 0xAE/0xAF clear or set disp_en.
- R9: After command 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA or 0xDB, the next byte taken in command mode is discarded and the interpreter stays in command mode. An end of transaction does not cancel the pending discard.
- R10: Commands 0x40 to 0x7F leave start_line at 0. Commands 0xC0 to 0xC8 and 0xE3 have no effect. Any other command byte gives a one-cycle bad_cmd pulse on the next cycle.
- R11: redraw is set by a framebuffer write or by invalidate, and is cleared by redraw_clr. When a set and a clear arrive on the same edge, the set wins.
- R12: in_ready is always high, and every byte with in_valid high is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready, always high |
| in_data | input | 8 | Byte stream data |
| xfer_end | input | 1 | End of bus transaction strobe |
| invalidate | input | 1 | External request to set redraw |
| redraw_clr | input | 1 | Refresh logic consumed the picture |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 11 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| page | output | 3 | Current page address |
| column | output | 8 | Current column address |
| start_line | output | 6 | Display start line |
| mirror | output | 1 | Horizontal mirror flag |
| all_on | output | 1 | All pixels on flag |
| inverse | output | 1 | Inverse video flag |
| disp_en | output | 1 | Display enable flag |
| redraw | output | 1 | Sticky picture-changed flag |
| bad_ctrl | output | 1 | Unexpected control byte pulse |
| bad_cmd | output | 1 | Unknown command pulse |

## Verification
The mode and pending-argument state are not visible at the ports, so a fault there shows up indirectly. It appears on the next byte as a write where a bad_ctrl pulse was expected, or as a command byte that changes a flag when it should have been swallowed. In either case the wrong pulse or register value appears one cycle after that byte. An error in the column or page registers shows up as a wrong fb_addr on the following data byte. It also shows up directly on the column and page outputs. A wrong boundary compare shows up as a write, or a missing write, at columns 131 and 132.

// File: rtl/oled_pkg.sv
package oled_pkg;

  localparam logic [7:0] CTRL_TO_CMD  = 8'h80;
  localparam logic [7:0] CTRL_TO_DATA = 8'h40;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_DATA = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    OP_COL_LO,
    OP_COL_HI,
    OP_START,
    OP_PAGE,
    OP_MIRROR,
    OP_ALLON,
    OP_INV,
    OP_ENABLE,
    OP_SKIPARG,
    OP_NOP,
    OP_BAD
  } op_e;

  typedef struct packed {
    op_e  op;
    logic val;
  } cmd_t;

endpackage

// File: rtl/oled_cmd_decode.sv
module oled_cmd_decode
  import oled_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       cmd
);

  always_comb begin
    cmd.val = code[0];
    cmd.op  = OP_BAD;
    if (code[7:4] == 4'h0) begin
      cmd.op = OP_COL_LO;
    end else if (code[7:4] == 4'h1 || code == 8'h20) begin
      cmd.op = OP_COL_HI;
    end else if (code[7:6] == 2'b01) begin
      cmd.op = OP_START;
    end else if (code[7:4] == 4'hB) begin
      cmd.op = OP_PAGE;
    end else if ((code >= 8'hC0 && code <= 8'hC8) || code == 8'hE3) begin
      cmd.op = OP_NOP;
    end else begin
      case (code)
        8'hA0, 8'hA1: cmd.op = OP_MIRROR;
        8'hA4, 8'hA5: cmd.op = OP_ALLON;
        8'hA6, 8'hA7: cmd.op = OP_INV;
        8'hAE, 8'hAF: cmd.op = OP_ENABLE;
        8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
        8'hD8, 8'hD9, 8'hDA, 8'hDB: cmd.op = OP_SKIPARG;
        default: cmd.op = OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/oled_addr_gen.sv
module oled_addr_gen #(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  localparam int CW = 8,
  localparam int PW = $clog2(PAGES),
  localparam int AW = $clog2(COLS * PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_take,
  input  logic          set_lo,
  input  logic          set_hi,
  input  logic          set_page,
  input  logic [3:0]    nib,
  input  logic [PW-1:0] pg,
  output logic [CW-1:0] column,
  output logic [PW-1:0] page,
  output logic          in_range,
  output logic [AW-1:0] lin_addr
);

  assign in_range = (32'(column) < COLS);
  assign lin_addr = AW'(column) + AW'(page) * AW'(COLS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      column <= '0;
      page   <= '0;
    end else begin
      if (wr_take && in_range) column <= column + 1'b1;
      else if (set_lo)         column <= {column[7:4], nib};
      else if (set_hi)         column <= {nib, column[3:0]};
      if (set_page) page <= pg;
    end
  end

endmodule

// File: rtl/oled_cmd_parser.sv
module oled_cmd_parser
  import oled_pkg::*;
#(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  localparam int CW = 8,
  localparam int PW = $clog2(PAGES),
  localparam int AW = $clog2(COLS * PAGES),
  localparam int SLW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           xfer_end,
  input  logic           invalidate,
  input  logic           redraw_clr,
  output logic           fb_we,
  output logic [AW-1:0]  fb_addr,
  output logic [7:0]     fb_wdata,
  output logic [PW-1:0]  page,
  output logic [CW-1:0]  column,
  output logic [SLW-1:0] start_line,
  output logic           mirror,
  output logic           all_on,
  output logic           inverse,
  output logic           disp_en,
  output logic           redraw,
  output logic           bad_ctrl,
  output logic           bad_cmd
);

  mode_e mode_q, mode_d;
  logic  pend_q, pend_d;
  cmd_t  cmd;
  logic  take, cmd_exec, skip_now, data_take, in_range, wr_ok;
  logic [AW-1:0] lin_addr;

  assign in_ready  = 1'b1;
  assign take      = in_valid && in_ready;
  assign cmd_exec  = take && mode_q == MODE_CMD && !pend_q;
  assign skip_now  = take && mode_q == MODE_CMD && pend_q;
  assign data_take = take && mode_q == MODE_DATA;
  assign wr_ok     = data_take && in_range;

  oled_cmd_decode u_dec (
    .code (in_data),
    .cmd  (cmd)
  );

  oled_addr_gen #(.COLS(COLS), .PAGES(PAGES)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_take  (data_take),
    .set_lo   (cmd_exec && cmd.op == OP_COL_LO),
    .set_hi   (cmd_exec && cmd.op == OP_COL_HI),
    .set_page (cmd_exec && cmd.op == OP_PAGE),
    .nib      (in_data[3:0]),
    .pg       (in_data[PW-1:0]),
    .column   (column),
    .page     (page),
    .in_range (in_range),
    .lin_addr (lin_addr)
  );

  // Mode sequencing: the byte is handled in the current mode, then end wins.
  always_comb begin
    mode_d = mode_q;
    pend_d = pend_q;
    if (take) begin
      unique case (mode_q)
        MODE_IDLE: begin
          if (in_data == CTRL_TO_CMD)       mode_d = MODE_CMD;
          else if (in_data == CTRL_TO_DATA) mode_d = MODE_DATA;
        end
        MODE_CMD: begin
          if (pend_q) begin
            pend_d = 1'b0;
          end else begin
            mode_d = MODE_IDLE;
            pend_d = (cmd.op == OP_SKIPARG);
          end
        end
        default: mode_d = mode_q;
      endcase
    end
    if (xfer_end) mode_d = MODE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_IDLE;
      pend_q     <= 1'b0;
      start_line <= '0;
      mirror     <= 1'b0;
      all_on     <= 1'b0;
      inverse    <= 1'b0;
      disp_en    <= 1'b0;
      redraw     <= 1'b1;
      fb_we      <= 1'b0;
      fb_addr    <= '0;
      fb_wdata   <= '0;
      bad_ctrl   <= 1'b0;
      bad_cmd    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pend_q   <= pend_d;
      fb_we    <= wr_ok;
      bad_ctrl <= take && mode_q == MODE_IDLE &&
                  in_data != CTRL_TO_CMD && in_data != CTRL_TO_DATA;
      bad_cmd  <= cmd_exec && cmd.op == OP_BAD;
      redraw   <= (redraw && !redraw_clr) || wr_ok || invalidate;
      if (wr_ok) begin
        fb_addr  <= lin_addr;
        fb_wdata <= in_data;
      end
      if (cmd_exec) begin
        unique case (cmd.op)
          OP_START:  start_line <= '0;
          OP_MIRROR: mirror     <= cmd.val;
          OP_ALLON:  all_on     <= cmd.val;
          OP_INV:    inverse    <= cmd.val;
          OP_ENABLE: disp_en    <= cmd.val;
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/oled_cmd_parser_chk.sv
module oled_cmd_parser_chk #(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  localparam int AW = $clog2(COLS * PAGES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          xfer_end,
  input logic [1:0]    mode,
  input logic          pend,
  input logic          fb_we,
  input logic [AW-1:0] fb_addr,
  input logic          redraw,
  input logic          bad_ctrl,
  input logic          bad_cmd
);

  // R4
  end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_end) |-> mode == 2'd0);

  // R3
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> 32'(fb_addr) < COLS * PAGES);

  // R3
  write_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> ($past(mode) == 2'd2 && $past(in_valid)));

  // R11
  write_sets_redraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> redraw);

  // R2
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fb_we, bad_ctrl, bad_cmd}));

  // R9
  skip_holds_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1 && pend && !xfer_end) |=> (mode == 2'd1 && !pend));

  // R5
  cmd_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1 && !pend) |=> mode == 2'd0);

endmodule

bind oled_cmd_parser oled_cmd_parser_chk #(.COLS(COLS), .PAGES(PAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .xfer_end (xfer_end),
  .mode     (mode_q),
  .pend     (pend_q),
  .fb_we    (fb_we),
  .fb_addr  (fb_addr),
  .redraw   (redraw),
  .bad_ctrl (bad_ctrl),
  .bad_cmd  (bad_cmd)
);

// File: tb/oled_cmd_parser_tb.sv
`timescale 1ns/1ps
module oled_cmd_parser_tb;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, xfer_end = 0, invalidate = 0, redraw_clr = 0;
  logic [7:0] in_data = 0;
  logic in_ready, fb_we, mirror, all_on, inverse, disp_en, redraw, bad_ctrl, bad_cmd;
  logic [10:0] fb_addr;
  logic [7:0] fb_wdata, column;
  logic [2:0] page;
  logic [5:0] start_line;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state: mode 0 idle, 1 cmd, 2 data
  int m_mode, m_col, m_page;
  bit m_pend, m_mir, m_all, m_inv, m_en, m_red;

  always #5 clk = ~clk;

  oled_cmd_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .xfer_end(xfer_end), .invalidate(invalidate),
    .redraw_clr(redraw_clr), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_wdata(fb_wdata), .page(page), .column(column), .start_line(start_line),
    .mirror(mirror), .all_on(all_on), .inverse(inverse), .disp_en(disp_en),
    .redraw(redraw), .bad_ctrl(bad_ctrl), .bad_cmd(bad_cmd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Model one command byte; returns 1 when the byte is unknown.
  function automatic bit model_cmd(input logic [7:0] b);
    if (b <= 8'h0F) m_col = (m_col & 8'hF0) | b[3:0];
    else if (b <= 8'h20) m_col = (m_col & 8'h0F) | (int'(b[3:0]) << 4);
    else if (b >= 8'h40 && b <= 8'h7F) ;
    else if (b >= 8'hB0 && b <= 8'hBF) m_page = b[2:0];
    else if ((b >= 8'hC0 && b <= 8'hC8) || b == 8'hE3) ;
    else begin
      case (b)
        8'hA0: m_mir = 0;  8'hA1: m_mir = 1;
        8'hA4: m_all = 0;  8'hA5: m_all = 1;
        8'hA6: m_inv = 0;  8'hA7: m_inv = 1;
        8'hAE: m_en = 0;   8'hAF: m_en = 1;
        8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5, 8'hD8, 8'hD9, 8'hDA, 8'hDB: m_pend = 1;
        default: return 1;
      endcase
    end
    return 0;
  endfunction

  task automatic compare_state(input bit e_we, input int e_addr, input int e_wd,
                               input bit e_bc, input bit e_bk);
    chk("R3 fb_we", fb_we, e_we);
    if (e_we) begin
      chk("R3 fb_addr", fb_addr, e_addr);
      chk("R3 fb_wdata", fb_wdata, e_wd);
    end
    chk("R2 bad_ctrl", bad_ctrl, e_bc);
    chk("R10 bad_cmd", bad_cmd, e_bk);
    chk("R6 column", column, m_col);
    chk("R7 page", page, m_page);
    chk("R8 mirror", mirror, m_mir);
    chk("R8 all_on", all_on, m_all);
    chk("R8 inverse", inverse, m_inv);
    chk("R8 disp_en", disp_en, m_en);
    chk("R10 start_line", start_line, 0);
    chk("R11 redraw", redraw, m_red);
    chk("R12 in_ready", in_ready, 1);
  endtask

  task automatic step(input logic [7:0] b, input bit v, input bit e,
                      input bit inv, input bit clr);
    bit e_we = 0, e_bc = 0, e_bk = 0;
    int e_addr = 0;
    @(negedge clk);
    in_valid = v; in_data = b; xfer_end = e; invalidate = inv; redraw_clr = clr;
    if (v) begin
      case (m_mode)
        0: if (b == 8'h80) m_mode = 1; else if (b == 8'h40) m_mode = 2; else e_bc = 1;
        2: if (m_col < 132) begin
             e_we = 1; e_addr = m_col + m_page * 132; m_col++;
           end
        default: if (m_pend) m_pend = 0;
                 else begin m_mode = 0; e_bk = model_cmd(b); end
      endcase
    end
    if (e) m_mode = 0;
    m_red = (m_red && !clr) || e_we || inv;
    @(negedge clk);
    in_valid = 0; xfer_end = 0; invalidate = 0; redraw_clr = 0;
    compare_state(e_we, e_addr, int'(b), e_bc, e_bk);
  endtask

  task automatic cmd1(input logic [7:0] b);
    step(8'h80, 1, 0, 0, 0);
    step(b, 1, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_mode = 0; m_col = 0; m_page = 0; m_pend = 0;
    m_mir = 0; m_all = 0; m_inv = 0; m_en = 0; m_red = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    compare_state(0, 0, 0, 0, 0);

    // R7, R6: page 3, column 130, then R3 boundary writes and drop
    cmd1(8'hB3);
    cmd1(8'h18);
    cmd1(8'h02);
    step(8'h40, 1, 0, 0, 0);
    step(8'hAA, 1, 0, 0, 0);
    step(8'hBB, 1, 0, 0, 0);
    step(8'hCC, 1, 1, 0, 0);
    // R4: after end, 0x55 in idle is an unexpected control byte
    step(8'h55, 1, 0, 0, 0);
    // R6: 0x20 clears the high nibble
    cmd1(8'h20);
    // R9: argument swallow keeps command mode
    cmd1(8'h81);
    step(8'h80, 1, 0, 0, 0);
    step(8'hA7, 1, 0, 0, 0);
    step(8'hA7, 1, 0, 0, 0);
    // R8 flags
    cmd1(8'hA1); cmd1(8'hA5); cmd1(8'hAF); cmd1(8'hA6);
    // R10: unknown, start line, no-op
    cmd1(8'h21); cmd1(8'h5F); cmd1(8'hC4); cmd1(8'hE3); cmd1(8'h82);
    // R4: control byte and end together, next data byte is not written
    step(8'h40, 1, 1, 0, 0);
    step(8'hAA, 1, 0, 0, 0);
    // R11: clear, then set and clear together
    step(8'h00, 0, 0, 0, 1);
    step(8'h00, 0, 0, 1, 1);
    step(8'h00, 0, 0, 0, 1);
    // R5: two commands without a new prefix: second is a control byte
    cmd1(8'hB1);
    step(8'hB2, 1, 0, 0, 0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] b;
      int r = $urandom % 100;
      if (r < 20)      b = ($urandom % 2) ? 8'h80 : 8'h40;
      else if (r < 35) b = 8'h00 + 8'($urandom % 16);
      else if (r < 45) b = 8'h10 + 8'($urandom % 17);
      else if (r < 55) b = 8'hB0 + 8'($urandom % 16);
      else if (r < 70) begin
        case ($urandom % 6)
          0: b = 8'h81; 1: b = 8'hD9; 2: b = 8'hA0 + 8'($urandom % 8);
          3: b = 8'hAE + 8'($urandom % 2); 4: b = 8'hC0 + 8'($urandom % 9);
          default: b = 8'hE3;
        endcase
      end
      else b = 8'($urandom);
      step(b, ($urandom % 8) != 0, ($urandom % 12) == 0,
           ($urandom % 20) == 0, ($urandom % 4) == 0);
    end
    finish_run();
  end

endmodule